// File: doc/BRIEF.md
# Register-Configured Pin Remapping Crossbar

This block connects a set of peripheral signals to a set of general-purpose pins through two multiplexer arrays whose select codes sit in configuration registers. On the drive side, every pin owns a code field that names one peripheral output, or none. A pin can therefore never carry two functions, while one function can be placed on several pins at once to put drivers in parallel. On the sample side, every peripheral input owns a field that names the pin it listens to. A function can therefore never see two pins, while one pin can feed several functions, for example a receive line and an edge-capture input together.

Software programs the fields through a small synchronous write port and reads them back through a combinational read port. A write changes the routing at the next clock edge. This lets a single hardware UART be moved from one pair of pins to another between transfers. Out of reset no pin is driven, and every peripheral input sees a constant high level, which is the idle state of a serial receive line.

Top module: `pin_remap_xbar`

## Requirements
- R1: While reset is active and after reset is released, every `pin_out` and `pin_oe` bit is 0 and every `fn_in` bit is 1. Every pin code field reads back 0, and every input select field reads back 31.
- R2: A pin whose code c is in 1..15 drives `pin_out[p] = fn_out[c-1]`. For example, code 3 selects `fn_out[2]` (UART 1 transmit) and code 7 selects `fn_out[6]` (SPI serial data out).
- R3: A pin whose code is 0 has `pin_out` = 0 and `pin_oe` = 0, whatever the peripheral signals are.
- R4: A pin whose code c is nonzero has `pin_oe[p] = fn_oe[c-1]`, so the pin is enabled only while the selected function enables its output.
- R5: When several pins hold the same code, all of them carry the same function value and enable.
- R6: An input function f whose select s is in 0..15 receives `fn_in[f] = pin_in[s]`. Several functions may select the same pin.
- R7: An input function whose select is 16 or larger receives a constant 1.
- R8: The address map is fixed. Addresses 0..15 hold the 4-bit code of pins 0..15 in `cfg_wdata[3:0]`. Addresses 16..23 hold the 5-bit select of input functions 0..7 in `cfg_wdata[4:0]`. Higher data bits are dropped and read back as 0. A write sampled at a rising edge changes routing and readback only after that edge, and the fields do not change without a write.
- R9: A write to addresses 24..31 changes no field, and a read of those addresses returns 0.
- R10: `cfg_rdata` shows the field at the current `cfg_addr` in the same cycle, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration field address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Read-back of the addressed field |
| fn_out | input | 15 | Peripheral output values, bit i selected by code i+1 |
| fn_oe | input | 15 | Peripheral output enables, bit i selected by code i+1 |
| pin_in | input | 16 | Levels sampled from the pins |
| pin_out | output | 16 | Values driven toward the pins |
| pin_oe | output | 16 | Per-pin output enables |
| fn_in | output | 8 | Peripheral input values routed from the pins |

## Verification
The drive side is tested first with one function placed on two pins, and then with two different functions on two pins. These cases separate correct fan-out from crossed or stuck selections. The enable and the data of a function are toggled separately, so a swap of `fn_oe` and `fn_out` shows up. On the sample side, pin levels are walked while two functions share one pin and a third function selects the highest pin, then a value beyond the pin count. This exposes off-by-one indexing and a missing default. Writes are observed just before and just after their edge, writes carry dirty upper data bits, and writes go to unmapped addresses, to pin down timing, truncation and decode.

// File: rtl/pin_remap_pkg.sv
package pin_remap_pkg;
  localparam int unsigned N_PINS      = 16;
  localparam int unsigned N_OUT_CODES = 16;
  localparam int unsigned N_IN_FN     = 8;
  localparam int unsigned OSEL_W      = 4;
  localparam int unsigned ISEL_W      = 5;
  localparam int unsigned CFG_AW      = 5;
  localparam int unsigned CFG_DW      = 8;
endpackage

// File: rtl/pin_remap_cfg.sv
module pin_remap_cfg #(
  parameter int unsigned NP  = 16,
  parameter int unsigned NIF = 8,
  parameter int unsigned OSW = 4,
  parameter int unsigned ISW = 5,
  parameter int unsigned AW  = 5,
  parameter int unsigned DW  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [AW-1:0]           cfg_addr,
  input  logic [DW-1:0]           cfg_wdata,
  output logic [DW-1:0]           cfg_rdata,
  output logic [NP-1:0][OSW-1:0]  osel,
  output logic [NIF-1:0][ISW-1:0] isel
);
  logic [NP-1:0][OSW-1:0]  osel_q, osel_d;
  logic [NIF-1:0][ISW-1:0] isel_q, isel_d;
  logic                    unused_wdata_hi;

  assign unused_wdata_hi = ^cfg_wdata[DW-1:ISW];

  // next-state: only the addressed field takes the write data
  always_comb begin
    osel_d = osel_q;
    isel_d = isel_q;
    for (int p = 0; p < NP; p++) begin
      if (cfg_addr == AW'(p)) osel_d[p] = cfg_wdata[OSW-1:0];
    end
    for (int f = 0; f < NIF; f++) begin
      if (cfg_addr == AW'(NP + f)) isel_d[f] = cfg_wdata[ISW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osel_q <= '0;
      isel_q <= '1;
    end else if (cfg_we) begin
      osel_q <= osel_d;
      isel_q <= isel_d;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    for (int p = 0; p < NP; p++) begin
      if (cfg_addr == AW'(p)) cfg_rdata = DW'(osel_q[p]);
    end
    for (int f = 0; f < NIF; f++) begin
      if (cfg_addr == AW'(NP + f)) cfg_rdata = DW'(isel_q[f]);
    end
  end

  assign osel = osel_q;
  assign isel = isel_q;

  // R8: fields change only through a write
  a_r8_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(osel_q) && $stable(isel_q)));

  // R9: unmapped addresses leave every field alone
  a_r9_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr >= AW'(NP + NIF)) |=> ($stable(osel_q) && $stable(isel_q)));

  for (genvar p = 0; p < NP; p++) begin : g_out_chk
    // R8: a pin code write is visible after the edge
    a_r8_pin_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == AW'(p)) |=> (osel_q[p] == $past(cfg_wdata[OSW-1:0])));
  end
endmodule

// File: rtl/pin_remap_out_mux.sv
module pin_remap_out_mux #(
  parameter int unsigned NP  = 16,
  parameter int unsigned NOC = 16,
  parameter int unsigned OSW = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NP-1:0][OSW-1:0] osel,
  input  logic [NOC-2:0]         fn_out,
  input  logic [NOC-2:0]         fn_oe,
  output logic [NP-1:0]          pin_out,
  output logic [NP-1:0]          pin_oe
);
  localparam int unsigned NCODE = 2 ** OSW;

  // code-indexed source table; code 0 and codes past the function count are dead
  logic [NCODE-1:0] src_dat, src_ena;

  for (genvar c = 0; c < NCODE; c++) begin : g_src
    if (c >= 1 && c < NOC) begin : g_live
      assign src_dat[c] = fn_out[c-1];
      assign src_ena[c] = fn_oe[c-1];
    end else begin : g_dead
      assign src_dat[c] = 1'b0;
      assign src_ena[c] = 1'b0;
    end
  end

  for (genvar p = 0; p < NP; p++) begin : g_pin
    assign pin_out[p] = src_dat[osel[p]];
    assign pin_oe[p]  = src_ena[osel[p]];

    // R3: an unassigned pin stays quiet
    a_r3_code_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (osel[p] == '0) |-> (!pin_oe[p] && !pin_out[p]));

    if (p > 0) begin : g_share
      // R5: pins sharing a code carry identical drive
      a_r5_shared_code_match: assert property (@(posedge clk) disable iff (!rst_n)
        (osel[p] == osel[0]) |-> (pin_out[p] == pin_out[0] && pin_oe[p] == pin_oe[0]));
    end
  end
endmodule

// File: rtl/pin_remap_in_mux.sv
module pin_remap_in_mux #(
  parameter int unsigned NP  = 16,
  parameter int unsigned NIF = 8,
  parameter int unsigned ISW = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NIF-1:0][ISW-1:0] isel,
  input  logic [NP-1:0]           pin_in,
  output logic [NIF-1:0]          fn_in
);
  localparam int unsigned NSRC = 2 ** ISW;

  // select-indexed source table; entries past the pin count idle high
  logic [NSRC-1:0] src;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    if (s < NP) begin : g_pin
      assign src[s] = pin_in[s];
    end else begin : g_idle
      assign src[s] = 1'b1;
    end
  end

  for (genvar f = 0; f < NIF; f++) begin : g_fn
    assign fn_in[f] = src[isel[f]];

    // R7: selects past the pin count read high
    a_r7_default_high: assert property (@(posedge clk) disable iff (!rst_n)
      (isel[f] >= ISW'(NP)) |-> fn_in[f]);

    if (f > 0) begin : g_share
      // R6: functions on the same pin see the same level
      a_r6_shared_pin_match: assert property (@(posedge clk) disable iff (!rst_n)
        (isel[f] == isel[0]) |-> (fn_in[f] == fn_in[0]));
    end
  end
endmodule

// File: rtl/pin_remap_xbar.sv
module pin_remap_xbar
  import pin_remap_pkg::*;
#(
  parameter int unsigned NP  = N_PINS,
  parameter int unsigned NOC = N_OUT_CODES,
  parameter int unsigned NIF = N_IN_FN,
  parameter int unsigned OSW = OSEL_W,
  parameter int unsigned ISW = ISEL_W,
  parameter int unsigned AW  = CFG_AW,
  parameter int unsigned DW  = CFG_DW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [AW-1:0]  cfg_addr,
  input  logic [DW-1:0]  cfg_wdata,
  output logic [DW-1:0]  cfg_rdata,
  input  logic [NOC-2:0] fn_out,
  input  logic [NOC-2:0] fn_oe,
  input  logic [NP-1:0]  pin_in,
  output logic [NP-1:0]  pin_out,
  output logic [NP-1:0]  pin_oe,
  output logic [NIF-1:0] fn_in
);
  logic [1:0]              rst_sync_q;
  logic                    rst_int_n;
  logic [NP-1:0][OSW-1:0]  osel;
  logic [NIF-1:0][ISW-1:0] isel;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pin_remap_cfg #(.NP(NP), .NIF(NIF), .OSW(OSW), .ISW(ISW), .AW(AW), .DW(DW)) u_cfg (
    .clk(clk), .rst_n(rst_int_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .osel(osel), .isel(isel)
  );

  pin_remap_out_mux #(.NP(NP), .NOC(NOC), .OSW(OSW)) u_out (
    .clk(clk), .rst_n(rst_int_n), .osel(osel), .fn_out(fn_out), .fn_oe(fn_oe),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  pin_remap_in_mux #(.NP(NP), .NIF(NIF), .ISW(ISW)) u_in (
    .clk(clk), .rst_n(rst_int_n), .isel(isel), .pin_in(pin_in), .fn_in(fn_in)
  );

  // R1: while the internal reset is held, nothing drives and inputs idle high
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_int_n |-> (pin_oe == '0 && fn_in == '1));
endmodule

// File: tb/pin_remap_xbar_tb_top.sv
`timescale 1ns/1ps
module pin_remap_xbar_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [4:0]  cfg_addr;
  logic [7:0]  cfg_wdata;
  logic [7:0]  cfg_rdata;
  logic [14:0] fn_out, fn_oe;
  logic [15:0] pin_in, pin_out, pin_oe;
  logic [7:0]  fn_in;

  always #2.5 clk = ~clk;

  pin_remap_xbar dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .fn_out(fn_out), .fn_oe(fn_oe),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .fn_in(fn_in)
  );

  typedef struct {
    logic [15:0] po;
    logic [15:0] poe;
    logic [7:0]  fi;
    logic [7:0]  rd;
    string       req;
  } exp_t;

  exp_t        sb_q[$];
  event        smp_ev;
  int          n_run  = 0;
  int          n_fail = 0;
  logic [3:0]  m_osel [16];
  logic [4:0]  m_isel [8];

  task automatic model_reset();
    for (int p = 0; p < 16; p++) m_osel[p] = 4'd0;
    for (int f = 0; f < 8; f++)  m_isel[f] = 5'd31;
  endtask

  // driver side: compute the expected view from the model and queue it
  task automatic sample(string req);
    exp_t e;
    for (int p = 0; p < 16; p++) begin
      e.po[p]  = (m_osel[p] == 0) ? 1'b0 : fn_out[m_osel[p] - 1];
      e.poe[p] = (m_osel[p] == 0) ? 1'b0 : fn_oe[m_osel[p] - 1];
    end
    for (int f = 0; f < 8; f++)
      e.fi[f] = (m_isel[f] < 16) ? pin_in[m_isel[f][3:0]] : 1'b1;
    if (cfg_addr < 16)      e.rd = {4'd0, m_osel[cfg_addr[3:0]]};
    else if (cfg_addr < 24) e.rd = {3'd0, m_isel[cfg_addr - 5'd16]};
    else                    e.rd = 8'd0;
    e.req = req;
    sb_q.push_back(e);
    ->smp_ev;
    #2;
  endtask

  // monitor side: pop and compare
  initial begin
    forever begin
      exp_t e;
      bit   bad;
      @(smp_ev);
      #1;
      e   = sb_q.pop_front();
      bad = 1'b0;
      n_run++;
      if (pin_out !== e.po) begin
        $display("FAIL %s pin_out actual %h expected %h", e.req, pin_out, e.po); bad = 1'b1;
      end
      if (pin_oe !== e.poe) begin
        $display("FAIL %s pin_oe actual %h expected %h", e.req, pin_oe, e.poe); bad = 1'b1;
      end
      if (fn_in !== e.fi) begin
        $display("FAIL %s fn_in actual %h expected %h", e.req, fn_in, e.fi); bad = 1'b1;
      end
      if (cfg_rdata !== e.rd) begin
        $display("FAIL %s cfg_rdata actual %h expected %h", e.req, cfg_rdata, e.rd); bad = 1'b1;
      end
      if (bad) n_fail++;
    end
  end

  task automatic cfg_write(logic [4:0] a, logic [7:0] d, string req, bit peek_before);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    if (peek_before) sample(req);
    @(negedge clk);
    cfg_we = 1'b0;
    if (a < 16)      m_osel[a[3:0]] = d[3:0];
    else if (a < 24) m_isel[a - 5'd16] = d[4:0];
  endtask

  task automatic read_all(string req);
    for (int a = 0; a < 32; a++) begin
      cfg_addr = 5'(a);
      sample(req);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    cfg_addr = 5'd0;
    sample("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual running expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    cfg_we = 1'b0; cfg_addr = 5'd0; cfg_wdata = 8'd0;
    fn_out = 15'h2A5C; fn_oe = 15'h7FFF; pin_in = 16'hA5C3;
    do_reset();
    read_all("R1");
    read_all("R9");

    // R2 / R4: UART tx code 3 on pin 3, SPI data code 7 on pin 9
    cfg_write(5'd3, 8'd3, "R8", 1'b1);
    cfg_write(5'd9, 8'd7, "R2", 1'b0);
    for (int v = 0; v < 4; v++) begin
      fn_out[2] = v[0]; fn_out[6] = ~v[0]; fn_oe[2] = v[1]; fn_oe[6] = ~v[1];
      sample("R2");
      sample("R4");
    end
    // R5: UART tx also on pin 5 and pin 15
    cfg_write(5'd5, 8'd3, "R5", 1'b0);
    cfg_write(5'd15, 8'd3, "R5", 1'b0);
    for (int v = 0; v < 4; v++) begin
      fn_out[2] = v[0]; fn_oe[2] = v[1];
      sample("R5");
    end
    // R3: unassign pin 3 while function stays active
    cfg_write(5'd3, 8'd0, "R3", 1'b0);
    fn_out = 15'h7FFF; fn_oe = 15'h7FFF;
    sample("R3");
    // highest code
    cfg_write(5'd0, 8'd15, "R2", 1'b0);
    fn_out[14] = 1'b0; sample("R2");
    fn_out[14] = 1'b1; sample("R2");

    // R6: functions 0 and 1 share pin 4, function 2 on pin 15
    cfg_write(5'd16, 8'd4, "R6", 1'b0);
    cfg_write(5'd17, 8'd4, "R6", 1'b0);
    cfg_write(5'd18, 8'd15, "R6", 1'b0);
    for (int v = 0; v < 6; v++) begin
      pin_in = 16'(16'h1 << v) ^ (v[0] ? 16'h8010 : 16'h0000);
      sample("R6");
    end
    // R7: select 16 and 20 default high
    cfg_write(5'd19, 8'd16, "R7", 1'b0);
    cfg_write(5'd20, 8'd20, "R7", 1'b0);
    pin_in = 16'h0000; sample("R7");
    // R8: dirty upper bits dropped
    cfg_write(5'd7, 8'hF5, "R8", 1'b0);
    cfg_write(5'd21, 8'hE3, "R8", 1'b0);
    cfg_addr = 5'd7;  sample("R8");
    cfg_addr = 5'd21; sample("R8");
    // R10: read follows address without a clock
    cfg_addr = 5'd9;  #0.5; sample("R10");
    cfg_addr = 5'd16; #0.5; sample("R10");
    // R9: unmapped write ignored
    cfg_write(5'd27, 8'hFF, "R9", 1'b0);
    cfg_write(5'd24, 8'h01, "R9", 1'b0);
    read_all("R9");
    // R8: retarget UART receive from pin 4 to pin 6, checked around the edge
    pin_in = 16'h0040;
    cfg_write(5'd16, 8'd6, "R8", 1'b1);
    sample("R8");
    pin_in = 16'h0010; sample("R8");
    // R1: second reset mid-run
    do_reset();
    read_all("R1");

    #10;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule